// File: doc/BRIEF.md
# Nibble-Wide Framed Word Link

This block carries one 8-, 16- or 32-bit value at a time over a 4-bit path between a core and a pin cell. It holds a sender and a receiver. The sender accepts a word and a size code on a valid/ready input. It then drives a frame onto its 4-bit output, one nibble per clock. The frame opens with a start marker. A nibble carrying the size code comes next. The payload nibbles follow, least significant first.

The receiver watches a 4-bit input. It locks onto the marker and reads the size code. It then collects the payload and presents the rebuilt word, widened to 32 bits, with a one-clock valid pulse. A whole frame costs 4, 6 or 10 clocks for the three sizes. Frames may follow each other with no idle gap.

Input back-pressure rules:
- The sender lowers `s_ready` for the whole frame.
- It raises `s_ready` again in the clock that carries the last payload nibble, so the next frame's marker can follow at once.
- A word is taken on a clock edge where `s_valid` and `s_ready` are both high.

The receive side cannot stall. The link has no flow control, so whatever consumes `m_valid`/`m_data` must take each word in the clock it is offered.

Top module: `nibble_link`

## Requirements
- R1: After reset, `link_out` is 0, `s_ready` is 1 and `m_valid` is 0.
- R2: A frame on `link_out` is laid out as follows. The first nibble is the marker `MARK` (default 4'hA). The second nibble is the size code zero-padded to `{2'b00, code}`, where code 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. The marker appears in the clock after the accepting edge.
- R3: The payload follows the size nibble with one nibble per clock. Nibble j carries `s_data[4j+3:4j]`, starting at j = 0.
- R4: A frame occupies the bus for 4, 6 or 10 clocks for codes 0, 1 and 2. `s_ready` is low from the accepting edge until the clock that carries the last payload nibble.
- R5: With `s_valid` held high, consecutive accepts are exactly one frame length apart. The next marker directly follows the last payload nibble.
- R6: Timing and content of the received word:
  - The receiver raises `m_valid` for exactly one clock, in the clock after the edge that samples the last payload nibble.
  - `m_data` holds the rebuilt word and `m_size` holds the received code.
  - In loopback this is 2+N clocks after the accepting edge, where N is the number of payload nibbles.
- R7: For codes 0 and 1, `m_data` is zero-extended to 32 bits. Bits of `s_data` above the selected size never reach `m_data`.
- R8: The receiver discards any size nibble that is not 0, 1 or 2. It produces no `m_valid` for it and is ready for a marker on the very next clock.
- R9: A sender code of 3 produces a two-nibble frame (marker, then 4'h3) with no payload. `link_out` returns to 0 whenever no frame is in flight.
- R10: While idle, the receiver ignores every nibble other than the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Word offered to the sender |
| s_ready | output | 1 | Sender can take a word this clock |
| s_data | input | 32 | Word to send |
| s_size | input | 2 | Size code of the offered word |
| link_out | output | 4 | Nibble bus driven by the sender |
| link_in | input | 4 | Nibble bus watched by the receiver |
| m_valid | output | 1 | One-clock pulse: received word present |
| m_data | output | 32 | Received word, zero-extended |
| m_size | output | 2 | Size code of the received word |

## Verification
The bench builds the block with its default parameters: a 32-bit word and marker 4'hA. With these defaults all three payload lengths are reachable, including the full 8-nibble frame and the index wrap of the receiver's collector. In loopback, random back-to-back frames test the zero-gap hand-off between frames. A second phase drives the receiver input directly. It feeds noise nibbles, illegal size codes, and a marker arriving right after a discarded header, none of which the sender would produce.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_SIZE = 2'd1,
    RX_PAY  = 2'd2
  } rx_state_e;

  // number of payload nibbles for a size code; 0 for an undefined code
  function automatic logic [3:0] payload_nibs(input logic [CODE_W-1:0] code);
    if (code == 2'd3) return 4'd0;
    return 4'd2 << code;
  endfunction

  function automatic logic code_ok(input logic [NIB_W-1:0] nib);
    return (nib[NIB_W-1:CODE_W] == '0) && (nib[CODE_W-1:0] != 2'd3);
  endfunction
endpackage

// File: rtl/nl_tx.sv
module nl_tx
  import nl_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [NIB_W-1:0] MARK  = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [CODE_W-1:0] s_size,
  output logic [NIB_W-1:0]  link_out
);
  localparam int CNT_W = $clog2(DATA_W / NIB_W) + 1;

  logic              busy, hdr;
  logic [CNT_W-1:0]  rem;
  logic [DATA_W-1:0] sh;
  logic [CODE_W-1:0] code_q;
  logic              accept;

  assign s_ready = !busy || (!hdr && rem == '0);
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hdr      <= 1'b0;
      rem      <= '0;
      sh       <= '0;
      code_q   <= '0;
      link_out <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      hdr      <= 1'b1;
      rem      <= CNT_W'(payload_nibs(s_size));
      sh       <= s_data;
      code_q   <= s_size;
      link_out <= MARK;
    end else if (busy && hdr) begin
      hdr      <= 1'b0;
      link_out <= {{(NIB_W-CODE_W){1'b0}}, code_q};
    end else if (busy && rem != '0) begin
      link_out <= sh[NIB_W-1:0];
      sh       <= sh >> NIB_W;
      rem      <= rem - 1'b1;
    end else begin
      busy     <= 1'b0;
      link_out <= '0;
    end
  end

  assert_marker_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (link_out == MARK));
  assert_hdr_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hdr) |-> !s_ready);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> (link_out == '0));
endmodule

// File: rtl/nl_rx.sv
module nl_rx
  import nl_pkg::*;
#(
  parameter int               DATA_W = 32,
  parameter logic [NIB_W-1:0] MARK   = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  link_in,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [CODE_W-1:0] m_size
);
  localparam int IDX_W = $clog2(DATA_W / NIB_W);

  rx_state_e         st;
  logic [IDX_W-1:0]  idx, last;
  logic [DATA_W-1:0] acc, acc_next;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    acc_next = acc | (DATA_W'(link_in) << {idx, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      idx     <= '0;
      last    <= '0;
      acc     <= '0;
      code_q  <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_size  <= '0;
    end else begin
      m_valid <= 1'b0;
      unique case (st)
        RX_IDLE: if (link_in == MARK) st <= RX_SIZE;
        RX_SIZE: begin
          if (code_ok(link_in)) begin
            st     <= RX_PAY;
            code_q <= link_in[CODE_W-1:0];
            last   <= IDX_W'(payload_nibs(link_in[CODE_W-1:0]) - 4'd1);
            idx    <= '0;
            acc    <= '0;
          end else begin
            st <= RX_IDLE;
          end
        end
        RX_PAY: begin
          acc <= acc_next;
          idx <= idx + 1'b1;
          if (idx == last) begin
            st      <= RX_IDLE;
            m_valid <= 1'b1;
            m_data  <= acc_next;
            m_size  <= code_q;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid);
  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_size == 2'd0) |-> (m_data[DATA_W-1:8] == '0));
  assert_noise_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_IDLE && link_in != MARK) |=> (st == RX_IDLE));
  assert_bad_code_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_SIZE && !code_ok(link_in)) |=> (st == RX_IDLE && !m_valid));
endmodule

// File: rtl/nibble_link.sv
module nibble_link
  import nl_pkg::*;
#(
  parameter int               DATA_W = 32,
  parameter logic [NIB_W-1:0] MARK   = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [CODE_W-1:0] s_size,
  output logic [NIB_W-1:0]  link_out,
  input  logic [NIB_W-1:0]  link_in,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [CODE_W-1:0] m_size
);
  nl_tx #(.DATA_W(DATA_W), .MARK(MARK)) u_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_size(s_size), .link_out(link_out)
  );

  nl_rx #(.DATA_W(DATA_W), .MARK(MARK)) u_rx (
    .clk(clk), .rst_n(rst_n), .link_in(link_in),
    .m_valid(m_valid), .m_data(m_data), .m_size(m_size)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (link_out == '0 && !m_valid));
endmodule

// File: tb/nibble_link_tb.sv
`timescale 1ns/1ps
module nibble_link_tb;
  localparam logic [3:0] MARK = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic [1:0]  s_size = '0;
  logic [3:0]  link_out, link_in, drv = '0;
  logic        use_direct = 1'b0;
  logic        m_valid;
  logic [31:0] m_data;
  logic [1:0]  m_size;

  int total = 0, bad = 0, cyc = 0, last_k = 0;
  int q_cyc[$];
  logic [31:0] q_data[$];
  logic [1:0]  q_size[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign link_in = use_direct ? drv : link_out;

  nibble_link u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_size(s_size), .link_out(link_out), .link_in(link_in),
    .m_valid(m_valid), .m_data(m_data), .m_size(m_size)
  );

  function automatic int nibs(input logic [1:0] c);
    return (c == 2'd3) ? 0 : (2 << c);
  endfunction
  function automatic logic [31:0] expect_word(input logic [31:0] d, input logic [1:0] c);
    return (c == 2'd0) ? {24'd0, d[7:0]} : (c == 2'd1) ? {16'd0, d[15:0]} : d;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // receiver monitor: every pulse must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n && m_valid) begin
      if (q_cyc.size() == 0) begin
        check(1'b0, "R8 unexpected m_valid", m_data, 32'h0);
      end else begin
        int ec;
        logic [31:0] ed;
        logic [1:0] es;
        ec = q_cyc.pop_front(); ed = q_data.pop_front(); es = q_size.pop_front();
        check(m_data == ed, "R6/R7 m_data", m_data, ed);
        check(m_size == es, "R6 m_size", 32'(m_size), 32'(es));
        check(cyc == ec, "R6 pulse cycle", cyc, ec);
      end
    end
  end

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [31:0] d, input logic [1:0] c);
    s_valid = 1'b1; s_data = d; s_size = c;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    last_k = cyc;
    if (c != 2'd3) begin
      q_cyc.push_back(cyc + 2 + nibs(c));
      q_data.push_back(expect_word(d, c));
      q_size.push_back(c);
    end
  endtask

  task automatic directed(input logic [31:0] d, input logic [1:0] c);
    send(d, c);
    s_valid = 1'b0;
    check(link_out == MARK, "R2 marker", 32'(link_out), 32'(MARK));
    check(!s_ready, "R4 ready low in frame", 32'(s_ready), 32'h0);
    @(negedge clk);
    check(link_out == {2'b00, c}, "R2 size nibble", 32'(link_out), 32'(c));
    for (int j = 0; j < nibs(c); j++) begin
      @(negedge clk);
      check(link_out == d[4*j +: 4], "R3 payload nibble", 32'(link_out), 32'(d[4*j +: 4]));
      if (j < nibs(c) - 1) check(!s_ready, "R4 ready low in frame", 32'(s_ready), 32'h0);
    end
    check(s_ready, "R4 ready on last nibble", 32'(s_ready), 32'h1);
    @(negedge clk);
    check(link_out == 4'h0, "R9 idle bus", 32'(link_out), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] n);
    @(negedge clk);
    drv = n;
  endtask

  initial begin
    #(5ns * 150000);
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] prev_c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(link_out == 4'h0, "R1 link_out reset", 32'(link_out), 32'h0);
    check(s_ready, "R1 s_ready reset", 32'(s_ready), 32'h1);
    check(!m_valid, "R1 m_valid reset", 32'(m_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    directed(32'hDEAD_C35A, 2'd0);
    directed(32'h1234_BEEF, 2'd1);
    directed(32'h1234_5678, 2'd2);
    directed(32'hFFFF_FFFF, 2'd3);

    // R5: back-to-back random frames
    prev_c = 2'd0;
    for (int i = 0; i < 60; i++) begin
      logic [1:0] c;
      int pk;
      c = 2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2));
      pk = last_k;
      send($urandom(), c);
      if (i > 0) check(last_k - pk == 2 + nibs(prev_c), "R5 zero-gap accept", last_k - pk, 2 + nibs(prev_c));
      prev_c = c;
    end
    s_valid = 1'b0;
    repeat (15) @(negedge clk);

    // direct drive of the receiver: noise, illegal codes, immediate re-sync
    use_direct = 1'b1;
    drive(4'h5); drive(4'hF); drive(4'h3);        // R10 noise
    drive(MARK); drive(4'h3);                      // R8 undefined code
    drive(MARK); drive(4'h1);                      // marker right after discard
    drive(4'h4); drive(4'h3); drive(4'h2); drive(4'h1);
    q_cyc.push_back(cyc + 1); q_data.push_back(32'h0000_1234); q_size.push_back(2'd1);
    drive(MARK); drive(4'h6);                      // R8 upper bits set
    drive(MARK); drive(4'h0); drive(4'h7); drive(4'h9);
    q_cyc.push_back(cyc + 1); q_data.push_back(32'h0000_0097); q_size.push_back(2'd0);
    drive(4'h0);
    repeat (4) @(negedge clk);
    check(q_cyc.size() == 0, "R6 all frames received", q_cyc.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule